// File: doc/BRIEF.md
# PC Card configuration register file

This block is the attribute-memory face of a removable storage card. A host reaches it over a byte-wide attribute port with an address, a write enable and separate read and write data. Addresses below a configurable base return bytes of a small read-only card information structure, or zero past its end. Addresses at and above the base reach four byte-wide configuration registers at even offsets. In offset order these are the option register, the configuration status register, the pin replacement register and the socket/copy register.

The block also produces the card's interrupt line. The line follows the device interrupt level, seen through the status register. Three sources hold it inactive: an interrupt-disable bit and a soft-reset bit from the host's device-control register, and the soft-reset bit of the option register. Writes to the status register can flip the power-down bit, and a flip sets a sticky card-ready flag that shows in the pin replacement register. The disk itself and its task-file registers sit outside this block.

Top module: `pccard_attr_regs`

## Requirements
- R1: After reset the option register reads 0x00 and the status register reads 0x00 while the device interrupt is low. The pin replacement register reads 0x0C, softResetReq is low, and cardIrqLine is high while the device interrupt is low and no gate is set.
- R2: A read at an address below ATTR_BASE and below CIS_LEN returns the information byte computed as the low 8 address bits XOR 0xA5. A read below ATTR_BASE at or past CIS_LEN returns 0x00.
- R3: A write to ATTR_BASE+0 with bit 7 clear stores the written value ANDed with 0xCF. The stored value reads back at the same address on the next cycle.
- R4: A write to ATTR_BASE+0 with bit 7 set does four things. It stores the value ANDed with 0xC0, so the mode field (bits 3..0) goes to 0. It clears the stored status bits and the card-ready flag. It drives softResetReq high until a later option write clears bit 7.
- R5: A write to ATTR_BASE+2 loads status bits 6, 5, 4 and 2 (mask 0x74) from the written value. Status bits 7, 3 and 0 always read 0, and bit 1 is never taken from the written value.
- R6: Status bit 1 reads as the device interrupt level registered one clock earlier. It reads 0 while hostIntDis is high.
- R7: A status write whose bit 2 differs from the stored power-down bit sets the card-ready flag. A status write that leaves bit 2 unchanged does not set it. Once set, only an R4 soft reset or the block reset clears it.
- R8: A read at ATTR_BASE+4 returns the card-ready flag at bit 5 ORed with 0x0C. A write there leaves the card-ready flag unchanged.
- R9: cardIrqLine is high exactly when status bit 1 (before the R6 masking) is 0, hostIntDis is low, hostSoftRst is low and option bit 7 is 0.
- R10: ATTR_BASE+6 and every other offset at or above ATTR_BASE that is not 0, 2 or 4 read 0x00, and writes to them change nothing. Writes below ATTR_BASE change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| attrAddr | input | ADDR_W | Attribute-space byte address |
| attrWrEn | input | 1 | Write strobe for the addressed byte |
| attrWrData | input | 8 | Write data |
| attrRdData | output | 8 | Read data, combinational from the address and registered state |
| devIrq | input | 1 | Device interrupt level |
| hostIntDis | input | 1 | Interrupt-disable bit of the host device-control register |
| hostSoftRst | input | 1 | Soft-reset bit of the host device-control register |
| softResetReq | output | 1 | High while option bit 7 is held set |
| cardIrqLine | output | 1 | Card interrupt line (high when no interrupt is pending and no gate applies) |

## Verification
The hardest condition to reach from the ports is a status write that leaves the power-down bit unchanged while the card-ready flag is still clear. Once any toggle has set the flag, only a soft reset clears it. The stimulus therefore first sets the flag, then writes the option register with bit 7 set to clear it, releases the soft reset, and only then issues two status writes: one that keeps bit 2 and one that flips it. The pin replacement register is read after each write. The interrupt gates are covered one at a time with the device interrupt both high and low, and the status read is repeated with the disable bit set.

// File: rtl/pcattr_pkg.sv
package pcattr_pkg;

  localparam logic [7:0] OPT_KEEP_MASK  = 8'hCF;
  localparam logic [7:0] OPT_SRST_MASK  = 8'hC0;
  localparam logic [7:0] STAT_WR_MASK   = 8'h74;
  localparam logic [7:0] PIN_FIXED_BITS = 8'h0C;
  localparam logic [7:0] CIS_SEED       = 8'hA5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CIS,
    SEL_OPT,
    SEL_STAT,
    SEL_PIN
  } rdSel_e;

  typedef struct packed {
    logic       wrOpt;
    logic       wrStat;
    rdSel_e     rdSel;
    logic [7:0] cisAddr;
  } strobes_t;

  function automatic logic [7:0] cisByte(input logic [7:0] idx);
    return idx ^ CIS_SEED;
  endfunction

endpackage

// File: rtl/pcattr_ctrl.sv
module pcattr_ctrl
  import pcattr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ATTR_BASE = 'h200,
  parameter int CIS_LEN   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] attrAddr,
  input  logic              attrWrEn,
  output strobes_t          strb
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(ATTR_BASE);
  localparam logic [ADDR_W-1:0] CIS_V  = ADDR_W'(CIS_LEN);
  localparam logic [ADDR_W-1:0] OFF_OPT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_PIN  = ADDR_W'(4);

  logic              belowBase;
  logic              inCis;
  logic [ADDR_W-1:0] regOff;

  always_comb begin
    belowBase = attrAddr < BASE_V;
    inCis     = attrAddr < CIS_V;
    regOff    = attrAddr - BASE_V;
  end

  always_comb begin
    strb.wrOpt   = 1'b0;
    strb.wrStat  = 1'b0;
    strb.rdSel   = SEL_NONE;
    strb.cisAddr = 8'(attrAddr);
    if (belowBase) begin
      if (inCis) strb.rdSel = SEL_CIS;
    end else begin
      unique case (regOff)
        OFF_OPT: begin
          strb.rdSel = SEL_OPT;
          strb.wrOpt = attrWrEn;
        end
        OFF_STAT: begin
          strb.rdSel  = SEL_STAT;
          strb.wrStat = attrWrEn;
        end
        OFF_PIN:  strb.rdSel = SEL_PIN;
        default:  strb.rdSel = SEL_NONE;
      endcase
    end
  end

  // R10: no register write may be decoded below the base
  a_r10_no_write_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    belowBase |-> !(strb.wrOpt || strb.wrStat));

  // R2: information bytes are selected only inside the ROM length
  a_r2_cis_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdSel == SEL_CIS) |-> (attrAddr < CIS_V));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrOpt, strb.wrStat}));

endmodule

// File: rtl/pcattr_dp.sv
module pcattr_dp
  import pcattr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobes_t   strb,
  input  logic [7:0] attrWrData,
  input  logic       devIrq,
  input  logic       hostIntDis,
  input  logic       hostSoftRst,
  output logic [7:0] attrRdData,
  output logic       softResetReq,
  output logic       cardIrqLine
);

  logic [7:0] optReg;
  logic [7:0] statStore;
  logic       readyBit;
  logic       intLatch;
  logic       pwrFlip;

  assign pwrFlip = statStore[2] ^ attrWrData[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      optReg    <= 8'h00;
      statStore <= 8'h00;
      readyBit  <= 1'b0;
      intLatch  <= 1'b0;
    end else begin
      intLatch <= devIrq;
      if (strb.wrOpt) begin
        if (attrWrData[7]) begin
          optReg    <= attrWrData & OPT_SRST_MASK;
          statStore <= 8'h00;
          readyBit  <= 1'b0;
        end else begin
          optReg <= attrWrData & OPT_KEEP_MASK;
        end
      end else if (strb.wrStat) begin
        if (pwrFlip) readyBit <= 1'b1;
        statStore <= attrWrData & STAT_WR_MASK;
      end
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CIS:  attrRdData = cisByte(strb.cisAddr);
      SEL_OPT:  attrRdData = optReg;
      SEL_STAT: attrRdData = statStore | {6'b0, intLatch & ~hostIntDis, 1'b0};
      SEL_PIN:  attrRdData = PIN_FIXED_BITS | {2'b0, readyBit, 5'b0};
      default:  attrRdData = 8'h00;
    endcase
  end

  assign softResetReq = optReg[7];
  assign cardIrqLine  = ~intLatch & ~hostIntDis & ~hostSoftRst & ~optReg[7];

  // R7: the ready flag falls only through a soft-reset option write
  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readyBit) |-> $past(strb.wrOpt && attrWrData[7]));

  // R7: a power-down flip leaves the ready flag set
  a_r7_flip_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrStat && pwrFlip) |=> readyBit);

  // R5: bits outside the write mask never read back from the store
  a_r5_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdSel == SEL_STAT) |-> (attrRdData[7] == 1'b0 && attrRdData[3] == 1'b0 && attrRdData[0] == 1'b0));

  // R4: the mode field is zero while a soft reset is held
  a_r4_mode_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    softResetReq |-> (optReg[3:0] == 4'h0));

endmodule

// File: rtl/pccard_attr_regs.sv
module pccard_attr_regs
  import pcattr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ATTR_BASE = 'h200,
  parameter int CIS_LEN   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] attrAddr,
  input  logic              attrWrEn,
  input  logic [7:0]        attrWrData,
  output logic [7:0]        attrRdData,
  input  logic              devIrq,
  input  logic              hostIntDis,
  input  logic              hostSoftRst,
  output logic              softResetReq,
  output logic              cardIrqLine
);

  strobes_t strb;

  pcattr_ctrl #(
    .ADDR_W   (ADDR_W),
    .ATTR_BASE(ATTR_BASE),
    .CIS_LEN  (CIS_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .attrAddr(attrAddr),
    .attrWrEn(attrWrEn),
    .strb    (strb)
  );

  pcattr_dp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .attrWrData  (attrWrData),
    .devIrq      (devIrq),
    .hostIntDis  (hostIntDis),
    .hostSoftRst (hostSoftRst),
    .attrRdData  (attrRdData),
    .softResetReq(softResetReq),
    .cardIrqLine (cardIrqLine)
  );

  localparam logic [ADDR_W-1:0] SOCK_ADDR = ADDR_W'(ATTR_BASE + 6);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(ATTR_BASE + 2);

  // R9: any of the three gates holds the line inactive
  a_r9_gates_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hostIntDis || hostSoftRst || softResetReq) |-> !cardIrqLine);

  // R10: socket/copy register reads zero
  a_r10_socket_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (attrAddr == SOCK_ADDR) |-> (attrRdData == 8'h00));

  // R6: the pending bit is hidden while interrupts are disabled
  a_r6_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (attrAddr == STAT_ADDR && hostIntDis) |-> !attrRdData[1]);

endmodule

// File: tb/pccard_attr_regs_tb.sv
`timescale 1ns/1ps
module pccard_attr_regs_tb;

  localparam int ADDR_W = 12;
  localparam int BASE   = 'h200;
  localparam int CISL   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] attrAddr = '0;
  logic              attrWrEn = 1'b0;
  logic [7:0]        attrWrData = 8'h00;
  logic [7:0]        attrRdData;
  logic              devIrq = 1'b0;
  logic              hostIntDis = 1'b0;
  logic              hostSoftRst = 1'b0;
  logic              softResetReq;
  logic              cardIrqLine;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  pccard_attr_regs #(.ADDR_W(ADDR_W), .ATTR_BASE(BASE), .CIS_LEN(CISL)) u_dut (
    .clk(clk), .rst_n(rst_n), .attrAddr(attrAddr), .attrWrEn(attrWrEn),
    .attrWrData(attrWrData), .attrRdData(attrRdData), .devIrq(devIrq),
    .hostIntDis(hostIntDis), .hostSoftRst(hostSoftRst),
    .softResetReq(softResetReq), .cardIrqLine(cardIrqLine)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    attrAddr   = ADDR_W'(a);
    attrWrData = d;
    attrWrEn   = 1'b1;
    @(negedge clk);
    attrWrEn   = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    attrAddr = ADDR_W'(a);
    #1;
    d = attrRdData;
  endtask

  task automatic waitCycle();
    @(negedge clk);
  endtask

  task automatic softReset();
    wr(BASE, 8'h80);
    wr(BASE, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(BASE, v);     check("R1 option", v, 8'h00);
    rd(BASE + 2, v); check("R1 status", v, 8'h00);
    rd(BASE + 4, v); check("R1 pin", v, 8'h0C);
    check("R1 softResetReq", {7'b0, softResetReq}, 8'h00);
    check("R1 cardIrqLine", {7'b0, cardIrqLine}, 8'h01);
  endtask

  task automatic t_cis();
    logic [7:0] v;
    rd(5, v);         check("R2 cis 5", v, 8'h05 ^ 8'hA5);
    rd(0, v);         check("R2 cis 0", v, 8'hA5);
    rd(CISL - 1, v);  check("R2 cis last", v, 8'((CISL - 1)) ^ 8'hA5);
    rd(CISL, v);      check("R2 past len", v, 8'h00);
    rd(BASE - 1, v);  check("R2 below base", v, 8'h00);
  endtask

  task automatic t_option();
    logic [7:0] v;
    wr(BASE, 8'h7F); rd(BASE, v); check("R3 opt 7F", v, 8'h4F);
    wr(BASE, 8'h31); rd(BASE, v); check("R3 opt 31", v, 8'h01);
    check("R3 no soft reset", {7'b0, softResetReq}, 8'h00);
    wr(BASE, 8'h00);
  endtask

  task automatic t_softreset();
    logic [7:0] v;
    wr(BASE + 2, 8'h74);
    rd(BASE + 4, v); check("R7 ready after flip", v, 8'h2C);
    wr(BASE, 8'h8F);
    rd(BASE, v);     check("R4 opt held", v, 8'h80);
    rd(BASE + 2, v); check("R4 status cleared", v, 8'h00);
    rd(BASE + 4, v); check("R4 ready cleared", v, 8'h0C);
    check("R4 softResetReq high", {7'b0, softResetReq}, 8'h01);
    check("R9 option gate", {7'b0, cardIrqLine}, 8'h00);
    wr(BASE, 8'h00);
    check("R4 softResetReq released", {7'b0, softResetReq}, 8'h00);
    check("R9 line back", {7'b0, cardIrqLine}, 8'h01);
  endtask

  task automatic t_status();
    logic [7:0] v;
    softReset();
    wr(BASE + 2, 8'h82);
    rd(BASE + 2, v); check("R5 bits 7,1 not written", v, 8'h00);
    rd(BASE + 4, v); check("R7 no flip no ready", v, 8'h0C);
    wr(BASE + 2, 8'h10);
    rd(BASE + 2, v); check("R5 status 10", v, 8'h10);
    rd(BASE + 4, v); check("R7 still not ready", v, 8'h0C);
    wr(BASE + 2, 8'hFF);
    rd(BASE + 2, v); check("R5 status FF", v, 8'h74);
    rd(BASE + 4, v); check("R7 flip sets ready", v, 8'h2C);
    wr(BASE + 2, 8'h10);
    rd(BASE + 4, v); check("R7 ready sticky", v, 8'h2C);
    wr(BASE + 4, 8'h00);
    rd(BASE + 4, v); check("R8 pin write keeps ready", v, 8'h2C);
    wr(BASE + 4, 8'hFF);
    rd(BASE + 4, v); check("R8 pin write no effect", v, 8'h2C);
  endtask

  task automatic t_interrupt();
    logic [7:0] v;
    softReset();
    @(negedge clk); devIrq = 1'b1;
    #1;
    check("R6 one cycle latency", {7'b0, cardIrqLine}, 8'h01);
    waitCycle();
    rd(BASE + 2, v); check("R6 pending bit", v, 8'h02);
    check("R9 pending line low", {7'b0, cardIrqLine}, 8'h00);
    hostIntDis = 1'b1;
    rd(BASE + 2, v); check("R6 hidden by disable", v, 8'h00);
    @(negedge clk); devIrq = 1'b0;
    waitCycle();
    check("R9 disable gate", {7'b0, cardIrqLine}, 8'h00);
    hostIntDis = 1'b0; #1;
    check("R9 no gate", {7'b0, cardIrqLine}, 8'h01);
    hostSoftRst = 1'b1; #1;
    check("R9 host reset gate", {7'b0, cardIrqLine}, 8'h00);
    hostSoftRst = 1'b0; #1;
    check("R9 host reset released", {7'b0, cardIrqLine}, 8'h01);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(BASE, 8'h03);
    wr(BASE + 2, 8'h20);
    wr(BASE + 6, 8'hFF);
    rd(BASE + 6, v); check("R10 socket reads 0", v, 8'h00);
    wr(BASE + 8, 8'hFF);
    wr(BASE + 1, 8'hFF);
    wr(5, 8'h55);
    rd(BASE, v);     check("R10 option untouched", v, 8'h03);
    rd(BASE + 2, v); check("R10 status untouched", v, 8'h20);
    rd(BASE + 1, v); check("R10 odd offset 0", v, 8'h00);
    rd(BASE + 8, v); check("R10 high offset 0", v, 8'h00);
    rd(5, v);        check("R10 cis unchanged", v, 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cis();
    t_option();
    t_softreset();
    t_status();
    t_interrupt();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule